// File: doc/BRIEF.md
# Prime-Modulo Interleaved Bank Mapper

This block sits in front of an interleaved word memory. The memory has a prime number of banks and a power-of-two number of words in each bank. Each incoming word address is split into a bank select and an in-bank offset. The bank select is the address reduced modulo the bank count. The offset is the address reduced modulo the words per bank, which is simply its low bits. The bank count is odd and the words per bank is a power of two, so the two are coprime. As a result, every address in the range 0 to banks×words−1 lands on its own (bank, offset) pair, and no divider is needed anywhere. The modulo is formed by a bit-serial residue chain that is unrolled into combinational logic.

Requests arrive on a valid/ready handshake. Each bank is modelled as busy for a fixed number of cycles after it is given a word. A request aimed at a busy bank is held off by dropping ready, and a request to an idle bank is accepted at once. An accepted request appears one cycle later as a registered bank select and offset, qualified by an output valid. With the default of 3 banks and a bank busy time of 3 cycles, both a unit-stride stream and a stride-8 stream flow at one word per cycle.

Top module: `prime_bank_mapper`

## Requirements
- R1: After reset, out_valid is 0 and req_ready is 1 for an address to any bank, because every bank is idle.
- R2: An accepted address A gives out_bank = A mod NBANKS and out_offset = A mod WORDS_PER_BANK (its low log2(WORDS_PER_BANK) bits) on the cycle after acceptance. For the defaults, NBANKS=3 and WORDS_PER_BANK=8.
- R3: With the defaults, address 16 maps to bank 1 offset 0, address 8 to bank 2 offset 0, address 9 to bank 0 offset 1, and address 23 to bank 2 offset 7.
- R4: With the defaults, the 24 addresses 0 to 23 produce 24 distinct (bank, offset) pairs.
- R5: out_valid is 1 on exactly those cycles that follow a cycle in which req_valid and req_ready were both 1.
- R6: After a bank accepts a request, a request to the same bank sees req_ready at 0 for ACCESS_CYC−1 cycles and is accepted ACCESS_CYC cycles after the first one. With ACCESS_CYC=3, this is 2 stall cycles.
- R7: A request to an idle bank is accepted on its first cycle, even while other banks are busy.
- R8: With the defaults, a unit-stride stream (0 to 23) and a stride-8 stream (0, 8, …, 248) are each accepted back to back with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Target bank idle, request will be taken |
| out_valid | output | 1 | Registered dispatch valid |
| out_bank | output | BANK_W | Selected bank, address mod NBANKS |
| out_offset | output | OFF_W | Word address within the bank |

## Verification
The bench walks a table of mapping points through the block and checks that every address in the unique range maps to its own pair. A residue chain that processes the bits in the wrong order, or that skips the final subtraction, would show up as wrong banks or as duplicate pairs. The bench counts stall cycles exactly for a same-bank follow-up. A busy counter that is one cycle off would produce one stall too many or too few, and a counter that never clears would hang the bench until the watchdog fires. It also runs requests to different banks while one bank is busy, and it runs the unit-stride and stride-8 streams. A ready signal that looks at the wrong bank, or at all banks together, would stall these requests. Finally, the bench resets the block while a bank is busy and checks that the bank becomes idle.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

    // One step of a most-significant-bit-first residue: r' = (2r + b) mod m.
    // The argument r must already be below m, so one conditional subtract suffices.
    function automatic int unsigned residue_step(int unsigned r, logic b, int unsigned m);
        int unsigned t;
        t = (r << 1) + int'(b);
        if (t >= m) t = t - m;
        return t;
    endfunction

endpackage

// File: rtl/bmap_residue.sv
module bmap_residue #(
    parameter int ADDR_W = 8,
    parameter int NBANKS = 3,
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] residue
);
    localparam int SUM_W = BANK_W + 1;
    localparam logic [SUM_W-1:0] MOD_L = SUM_W'(NBANKS);

    // partial[i] holds the residue of the top i address bits.
    logic [ADDR_W:0][BANK_W-1:0] partial;

    assign partial[0] = '0;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_stage
        logic [SUM_W-1:0] dbl;
        assign dbl = {partial[i], addr[ADDR_W-1-i]};
        assign partial[i+1] = (dbl >= MOD_L) ? BANK_W'(dbl - MOD_L) : BANK_W'(dbl);
    end

    assign residue = partial[ADDR_W];

endmodule

// File: rtl/bmap_bank_timers.sv
module bmap_bank_timers #(
    parameter int NBANKS     = 3,
    parameter int ACCESS_CYC = 3,
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [BANK_W-1:0] load_bank,
    output logic [NBANKS-1:0] busy
);
    localparam int CNT_W = $clog2(ACCESS_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ACCESS_CYC - 1);

    typedef struct packed {
        logic [NBANKS-1:0][CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBANKS; b++) begin
            if (load_en && (load_bank == BANK_W'(b))) begin
                st_d.cnt[b] = LOAD_VAL;
            end else if (st_q.cnt[b] != '0) begin
                st_d.cnt[b] = st_q.cnt[b] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_busy
        assign busy[b] = (st_q.cnt[b] != '0);
    end

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper #(
    parameter int ADDR_W         = 8,
    parameter int NBANKS         = 3,
    parameter int WORDS_PER_BANK = 8,
    parameter int ACCESS_CYC     = 3,
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int OFF_W  = (WORDS_PER_BANK > 1) ? $clog2(WORDS_PER_BANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              out_valid,
    output logic [BANK_W-1:0] out_bank,
    output logic [OFF_W-1:0]  out_offset
);
    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  off;
    } disp_state_t;

    disp_state_t st_d, st_q;

    logic [BANK_W-1:0] tgt_bank;
    logic [NBANKS-1:0] bank_busy;
    logic              fire;

    bmap_residue #(
        .ADDR_W (ADDR_W),
        .NBANKS (NBANKS)
    ) u_residue (
        .addr    (req_addr),
        .residue (tgt_bank)
    );

    bmap_bank_timers #(
        .NBANKS     (NBANKS),
        .ACCESS_CYC (ACCESS_CYC)
    ) u_timers (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (fire),
        .load_bank (tgt_bank),
        .busy      (bank_busy)
    );

    assign req_ready = !bank_busy[tgt_bank];
    assign fire      = req_valid && req_ready;

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire;
        if (fire) begin
            st_d.bank = tgt_bank;
            st_d.off  = req_addr[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_bank   = st_q.bank;
    assign out_offset = st_q.off;

endmodule

// File: rtl/bmap_checker.sv
module bmap_checker #(
    parameter int ADDR_W         = 8,
    parameter int NBANKS         = 3,
    parameter int WORDS_PER_BANK = 8,
    parameter int ACCESS_CYC     = 3,
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int OFF_W  = (WORDS_PER_BANK > 1) ? $clog2(WORDS_PER_BANK) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              out_valid,
    input logic [BANK_W-1:0] out_bank,
    input logic [OFF_W-1:0]  out_offset
);
    initial begin
        AST_COPRIME_CFG: assert ((NBANKS % 2 == 1) && ((WORDS_PER_BANK & (WORDS_PER_BANK - 1)) == 0)); // R4
    end

    AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid && req_ready)); // R5

    AST_MAP_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && out_bank == BANK_W'($past(req_addr) % NBANKS))); // R2

    AST_MAP_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_offset == OFF_W'($past(req_addr) % WORDS_PER_BANK))); // R2

    if (ACCESS_CYC > 1) begin : g_busy_chk
        AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_ready) |=>
            !(req_ready && (req_addr % NBANKS) == ($past(req_addr) % NBANKS))); // R6
    end

endmodule

bind prime_bank_mapper bmap_checker #(
    .ADDR_W         (ADDR_W),
    .NBANKS         (NBANKS),
    .WORDS_PER_BANK (WORDS_PER_BANK),
    .ACCESS_CYC     (ACCESS_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_bank   (out_bank),
    .out_offset (out_offset)
);

// File: tb/prime_bank_mapper_tb.sv
module prime_bank_mapper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NB = 3;
    localparam int WPB = 8;
    localparam int ACC = 3;

    localparam int NVEC = 7;
    localparam int VEC_A [NVEC] = '{16, 8, 9, 23, 0, 31, 255};
    localparam int VEC_B [NVEC] = '{1, 2, 0, 2, 0, 1, 0};
    localparam int VEC_O [NVEC] = '{0, 0, 1, 7, 0, 7, 7};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          out_valid;
    logic [1:0]    out_bank;
    logic [2:0]    out_offset;

    int n_chk = 0;
    int n_bad = 0;
    int got_bank, got_off, got_stalls;

    always #(CLK_PERIOD/2) clk = ~clk;

    prime_bank_mapper #(.ADDR_W(AW), .NBANKS(NB), .WORDS_PER_BANK(WPB), .ACCESS_CYC(ACC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .out_valid(out_valid), .out_bank(out_bank), .out_offset(out_offset)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge with the result captured.
    task automatic issue(input int a);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        got_stalls = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            got_stalls++;
        end
        @(negedge clk);
        check(out_valid === 1'b1, "R5 out_valid after accept", int'(out_valid), 1);
        got_bank = int'(out_bank);
        got_off  = int'(out_offset);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired R6 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit seen [NB*WPB];
        int total_stalls;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        for (int a = 0; a < NB; a++) begin
            req_addr = AW'(a);
            #1;
            check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        end
        @(negedge clk);

        // R2 / R3: table of mapping points
        for (int v = 0; v < NVEC; v++) begin
            issue(VEC_A[v]);
            check(got_bank == VEC_B[v], "R3 bank", got_bank, VEC_B[v]);
            check(got_off == VEC_O[v], "R3 offset", got_off, VEC_O[v]);
            idle(ACC);
        end

        // R5: nothing comes out while idle
        check(out_valid === 1'b0, "R5 idle out_valid", int'(out_valid), 0);

        // R4 / R8: unit stride stream, mapping and uniqueness
        for (int i = 0; i < NB*WPB; i++) seen[i] = 1'b0;
        total_stalls = 0;
        for (int a = 0; a < NB*WPB; a++) begin
            issue(a);
            total_stalls += got_stalls;
            check(got_bank == a % NB, "R2 bank", got_bank, a % NB);
            check(got_off == a % WPB, "R2 offset", got_off, a % WPB);
            check(!seen[got_bank*WPB + got_off], "R4 unique pair", a, -1);
            seen[got_bank*WPB + got_off] = 1'b1;
        end
        check(total_stalls == 0, "R8 unit stride stalls", total_stalls, 0);
        idle(ACC);

        // R8: stride-8 stream
        total_stalls = 0;
        for (int a = 0; a < 256; a += 8) begin
            issue(a);
            total_stalls += got_stalls;
            check(got_bank == a % NB, "R2 stride bank", got_bank, a % NB);
        end
        check(total_stalls == 0, "R8 stride-8 stalls", total_stalls, 0);
        idle(ACC);

        // R6: same-bank follow-up stalls ACC-1 cycles
        issue(0);
        issue(3);
        check(got_stalls == ACC-1, "R6 same bank stalls", got_stalls, ACC-1);
        check(got_bank == 0 && got_off == 3, "R6 held request result", got_bank*8+got_off, 3);
        idle(ACC);

        // R7: other banks proceed while one is busy
        issue(0);
        issue(1);
        check(got_stalls == 0, "R7 bank1 while bank0 busy", got_stalls, 0);
        issue(2);
        check(got_stalls == 0, "R7 bank2 while others busy", got_stalls, 0);
        issue(6);
        check(got_stalls == 0, "R7 bank0 free again", got_stalls, 0);
        issue(9);
        check(got_stalls == ACC-1, "R6 bank0 busy again", got_stalls, ACC-1);
        idle(1);
        check(out_valid === 1'b0, "R5 out_valid drops", int'(out_valid), 0);

        // R1: reset while a bank is busy clears it
        issue(4);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        req_addr = AW'(7);
        #1;
        check(req_ready === 1'b1, "R1 bank idle after reset", int'(req_ready), 1);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule